// File: doc/BRIEF.md
# Per-Channel Interrupt Mask and Ready Status

This block sits between eight serial channels and the interrupt lines of a host bus. Each channel supplies two ready flags: transmit-ready (its transmit holding register can take a character) and receive-ready (a received character is waiting). The block gates every flag with a bit of a software-written mask and drives sixteen registered, active-high interrupt outputs, one transmit and one receive per channel. Software can also read the flags directly and poll them as status, with or without interrupts enabled.

The register interface is one byte wide and is shared with the rest of the board's port block. It uses two write ports, one loading the transmit mask and one loading the receive mask. At the same two addresses there are two read ports that return the transmit and receive ready flags. An access is honoured only while the host's current channel selection falls on this board.

The two highest channels each carry one extra event: transmitter empty or modem-status change. A per-channel routing code folds that event into the channel's transmit path or its receive path. Both the interrupt and the status bit then show the merged value. Software reads the channel's own status to tell the causes apart.

Top module: `chan_irq_gate`

## Requirements
- R1: A write with `sel_local`=1 to address 4 loads `wdata` into the transmit mask. Bit n governs channel n, and 1 enables.
- R2: A write with `sel_local`=1 to address 5 loads `wdata` into the receive mask, with the same bit-to-channel mapping.
- R3: A read with `sel_local`=1 at address 4 returns the transmit status byte on `rdata` one clock later, and a read at address 5 returns the receive status byte. Bit n is channel n, and 1 means pending. The mask never changes the returned value.
- R4: Reset clears both masks, so all sixteen interrupt outputs are 0 after reset whatever the ready flags are.
- R5: `irq_tx[n]` (`irq_rx[n]`) is 1 only when channel n's effective transmit (receive) flag and its mask bit are both 1.
- R6: While `sel_local`=0, writes leave both masks unchanged and reads return 0 on `rdata`.
- R7: For channel 6+j (j=0,1), `evt_route[2j+1:2j]` = 2'b01 ORs `evt[j]` into that channel's transmit interrupt and transmit status bit. The value 2'b10 ORs it into the receive interrupt and receive status bit. The values 2'b00 and 2'b11 merge nothing.
- R8: Writing 0x52 to the transmit mask enables exactly channels 1, 4 and 6. A receive status of 0x8C reads back as 0x8C when channels 2, 3 and 7 have data.
- R9: A write or read at any address other than 4 or 5 leaves both masks unchanged, and a read there returns 0.
- R10: The interrupt outputs are registered. They change on the first clock edge after a flag change, or on the first edge after the edge that loads a mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_local | input | 1 | Current channel selection addresses this board |
| wr_en | input | 1 | Register write strobe (one cycle) |
| rd_en | input | 1 | Register read strobe (one cycle) |
| addr | input | 3 | Relative port address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| tx_rdy | input | 8 | Transmit-ready flag per channel |
| rx_rdy | input | 8 | Receive-ready flag per channel |
| evt | input | 2 | Extra event for channels 6 and 7 |
| evt_route | input | 4 | Routing code per extra channel (2 bits each) |
| irq_tx | output | 8 | Masked transmit interrupts |
| irq_rx | output | 8 | Masked receive interrupts |

## Verification
The hardest case to reach is the extra event merge. The event must reach the interrupt and the status bit together, while the channel's own ready flag is low, so that only the merge can explain a 1. The stimulus holds `tx_rdy` and `rx_rdy` at zero, opens both masks, and then drives each routing code in turn. It checks that the event shows up only on the selected side and only for the selected channel. Ignored accesses are shown at the ports: the bench writes while the board is deselected, then reselects it and observes that the interrupt outputs have not moved.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;
    localparam int ADDR_W = 3;
    // Port addresses that select the two mask/status registers.
    localparam logic [ADDR_W-1:0] PORT_TX = 3'd4;
    localparam logic [ADDR_W-1:0] PORT_RX = 3'd5;

    typedef enum logic [1:0] {
        ROUTE_NONE = 2'b00,
        ROUTE_TX   = 2'b01,
        ROUTE_RX   = 2'b10,
        ROUTE_OFF  = 2'b11
    } route_e;
endpackage

// File: rtl/chan_irq_regs.sv
module chan_irq_regs
    import chan_irq_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_local,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NUM_CH-1:0] wdata,
    input  logic [NUM_CH-1:0] tx_stat,
    input  logic [NUM_CH-1:0] rx_stat,
    output logic [NUM_CH-1:0] mask_tx,
    output logic [NUM_CH-1:0] mask_rx,
    output logic [NUM_CH-1:0] rdata
);
    typedef struct packed {
        logic [NUM_CH-1:0] mtx;
        logic [NUM_CH-1:0] mrx;
        logic [NUM_CH-1:0] rd;
    } regs_t;

    regs_t st_d, st_q;
    logic  hit_tx, hit_rx;

    always_comb begin
        hit_tx = sel_local && (addr == PORT_TX);
        hit_rx = sel_local && (addr == PORT_RX);
        st_d    = st_q;
        st_d.rd = '0;
        if (wr_en && hit_tx) st_d.mtx = wdata;
        if (wr_en && hit_rx) st_d.mrx = wdata;
        if (rd_en && hit_tx) st_d.rd  = tx_stat;
        if (rd_en && hit_rx) st_d.rd  = rx_stat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_tx = st_q.mtx;
    assign mask_rx = st_q.mrx;
    assign rdata   = st_q.rd;

    // R1
    tx_mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_local && addr == PORT_TX) |=> (mask_tx == $past(wdata)));
    // R2
    rx_mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_local && addr == PORT_RX) |=> (mask_rx == $past(wdata)));
    // R3
    tx_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel_local && addr == PORT_TX) |=> (rdata == $past(tx_stat)));
    // R6
    remote_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_local |=> ($stable(mask_tx) && $stable(mask_rx) && rdata == '0));
    // R9
    other_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != PORT_TX && addr != PORT_RX) |=> ($stable(mask_tx) && $stable(mask_rx)));
endmodule

// File: rtl/chan_irq_merge.sv
module chan_irq_merge
    import chan_irq_pkg::*;
#(
    parameter int NUM_CH    = 8,
    parameter int EXT_FIRST = 6,
    localparam int NUM_EXT  = NUM_CH - EXT_FIRST
) (
    input  logic [NUM_CH-1:0]    tx_rdy,
    input  logic [NUM_CH-1:0]    rx_rdy,
    input  logic [NUM_EXT-1:0]   evt,
    input  logic [2*NUM_EXT-1:0] evt_route,
    output logic [NUM_CH-1:0]    eff_tx,
    output logic [NUM_CH-1:0]    eff_rx
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        if (i >= EXT_FIRST) begin : g_ext
            route_e rt;
            assign rt = route_e'(evt_route[2*(i-EXT_FIRST) +: 2]);
            assign eff_tx[i] = tx_rdy[i] | (evt[i-EXT_FIRST] && rt == ROUTE_TX);
            assign eff_rx[i] = rx_rdy[i] | (evt[i-EXT_FIRST] && rt == ROUTE_RX);
        end else begin : g_plain
            assign eff_tx[i] = tx_rdy[i];
            assign eff_rx[i] = rx_rdy[i];
        end
    end

    // R7
    always_comb begin
        for (int j = 0; j < NUM_EXT; j++) begin
            if (evt[j] && evt_route[2*j +: 2] == ROUTE_TX)
                route_tx_chk: assert (eff_tx[EXT_FIRST+j]);
            if (evt[j] && evt_route[2*j +: 2] == ROUTE_RX)
                route_rx_chk: assert (eff_rx[EXT_FIRST+j]);
        end
    end
endmodule

// File: rtl/chan_irq_out.sv
module chan_irq_out #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] eff_tx,
    input  logic [NUM_CH-1:0] eff_rx,
    input  logic [NUM_CH-1:0] mask_tx,
    input  logic [NUM_CH-1:0] mask_rx,
    output logic [NUM_CH-1:0] irq_tx,
    output logic [NUM_CH-1:0] irq_rx
);
    typedef struct packed {
        logic [NUM_CH-1:0] tx;
        logic [NUM_CH-1:0] rx;
    } irq_t;

    irq_t irq_d, irq_q;

    always_comb begin
        irq_d.tx = eff_tx & mask_tx;
        irq_d.rx = eff_rx & mask_rx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign irq_tx = irq_q.tx;
    assign irq_rx = irq_q.rx;

    // R5
    masked_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_tx & ~$past(mask_tx)) == '0) && ((irq_rx & ~$past(mask_rx)) == '0));
    // R10
    flag_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(eff_tx) && $stable(mask_tx) |=> $stable(irq_tx));
endmodule

// File: rtl/chan_irq_gate.sv
module chan_irq_gate
    import chan_irq_pkg::*;
#(
    parameter int NUM_CH    = 8,
    parameter int EXT_FIRST = 6,
    localparam int NUM_EXT  = NUM_CH - EXT_FIRST
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_local,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_CH-1:0]    wdata,
    output logic [NUM_CH-1:0]    rdata,
    input  logic [NUM_CH-1:0]    tx_rdy,
    input  logic [NUM_CH-1:0]    rx_rdy,
    input  logic [NUM_EXT-1:0]   evt,
    input  logic [2*NUM_EXT-1:0] evt_route,
    output logic [NUM_CH-1:0]    irq_tx,
    output logic [NUM_CH-1:0]    irq_rx
);
    logic [NUM_CH-1:0] eff_tx, eff_rx, mask_tx, mask_rx;

    chan_irq_merge #(.NUM_CH(NUM_CH), .EXT_FIRST(EXT_FIRST)) u_merge (
        .tx_rdy(tx_rdy), .rx_rdy(rx_rdy), .evt(evt), .evt_route(evt_route),
        .eff_tx(eff_tx), .eff_rx(eff_rx));

    chan_irq_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel_local(sel_local), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .tx_stat(eff_tx),
        .rx_stat(eff_rx), .mask_tx(mask_tx), .mask_rx(mask_rx), .rdata(rdata));

    chan_irq_out #(.NUM_CH(NUM_CH)) u_out (
        .clk(clk), .rst_n(rst_n), .eff_tx(eff_tx), .eff_rx(eff_rx),
        .mask_tx(mask_tx), .mask_rx(mask_rx), .irq_tx(irq_tx), .irq_rx(irq_rx));

    // R4
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_tx == '0 && irq_rx == '0));
    // R3
    rx_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel_local && addr == PORT_RX) |=> (rdata == $past(eff_rx)));
endmodule

// File: tb/tb_chan_irq_gate.sv
module tb_chan_irq_gate;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_local = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0, rdata, tx_rdy = '0, rx_rdy = '0, irq_tx, irq_rx;
    logic [1:0] evt = '0;
    logic [3:0] evt_route = '0;
    int total = 0, bad = 0;

    always #4 clk = ~clk;

    chan_irq_gate dut (.*);

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); d = rdata; rd_en = 1'b0;
    endtask

    task automatic settle(); @(negedge clk); endtask

    task automatic t_reset();
        logic [7:0] d;
        tx_rdy = 8'hFF; rx_rdy = 8'hFF; settle();
        check("R4 irq_tx", irq_tx, 8'h00);
        check("R4 irq_rx", irq_rx, 8'h00);
        rd(3'd4, d); check("R3 tx status with mask clear", d, 8'hFF);
    endtask

    task automatic t_masks();
        logic [7:0] d;
        wr(3'd4, 8'h52); settle();
        check("R1 R8 irq_tx", irq_tx, 8'h52);
        wr(3'd5, 8'h8C); settle();
        check("R2 irq_rx", irq_rx, 8'h8C);
        rx_rdy = 8'h8C; settle();
        rd(3'd5, d); check("R8 rx status", d, 8'h8C);
        rx_rdy = 8'h31; settle();
        check("R5 irq_rx partial", irq_rx, 8'h00);
        rd(3'd5, d); check("R3 rx status unmasked", d, 8'h31);
        tx_rdy = 8'h0F; settle();
        check("R5 irq_tx partial", irq_tx, 8'h02);
    endtask

    task automatic t_timing();
        wr(3'd4, 8'hFF);
        check("R10 before edge", irq_tx, 8'h02);
        settle();
        check("R10 after edge", irq_tx, 8'h0F);
        @(negedge clk); tx_rdy = 8'hA0; #1;
        check("R10 flag no early change", irq_tx, 8'h0F);
        settle();
        check("R10 flag one edge", irq_tx, 8'hA0);
    endtask

    task automatic t_remote();
        logic [7:0] d;
        sel_local = 1'b0;
        wr(3'd4, 8'h00); wr(3'd5, 8'hFF);
        rd(3'd4, d); check("R6 remote read", d, 8'h00);
        sel_local = 1'b1; rx_rdy = 8'hFF; settle(); settle();
        check("R6 tx mask kept", irq_tx, 8'hA0);
        check("R6 rx mask kept", irq_rx, 8'h8C);
    endtask

    task automatic t_other();
        logic [7:0] d;
        wr(3'd3, 8'h00); wr(3'd6, 8'h00); wr(3'd0, 8'h00);
        settle();
        check("R9 tx mask kept", irq_tx, 8'hA0);
        check("R9 rx mask kept", irq_rx, 8'h8C);
        rd(3'd2, d); check("R9 other read", d, 8'h00);
    endtask

    task automatic t_merge();
        logic [7:0] d;
        tx_rdy = '0; rx_rdy = '0;
        wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
        evt = 2'b11; evt_route = 4'b0000; settle(); settle();
        check("R7 none tx", irq_tx, 8'h00);
        check("R7 none rx", irq_rx, 8'h00);
        evt_route = 4'b1001; settle(); settle();
        check("R7 ch6 to tx", irq_tx, 8'h40);
        check("R7 ch7 to rx", irq_rx, 8'h80);
        rd(3'd4, d); check("R7 tx status", d, 8'h40);
        rd(3'd5, d); check("R7 rx status", d, 8'h80);
        evt_route = 4'b0110; settle(); settle();
        check("R7 ch7 to tx", irq_tx, 8'h80);
        check("R7 ch6 to rx", irq_rx, 8'h40);
        evt_route = 4'b1111; settle(); settle();
        check("R7 code 11 tx", irq_tx, 8'h00);
        evt = '0;
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_masks();
        t_timing();
        t_remote();
        t_other();
        t_merge();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule